// File: doc/BRIEF.md
# Configuration Sequencer for an FPGA Loader

This block drives the start-up of a device that holds FPGA configuration images in an external flash. Out of reset it reads a fixed block of 32 sixteen-bit option words from flash, one read at a time and at a slow fixed pace. From those words it keeps a header and a page table. The header gives the data-path scheme code, the decompression enable and the streaming clock divider. The page table holds a start address and a length in words for each of eight stored images.

Once the options are loaded, the block uses a 3-bit page number to pick a page. The number was captured while reset was held, or at the last reconfigure pulse. The block then waits for the FPGA to report that it can accept data: its status line high and its done line low. It then reads the chosen page word by word from flash, at a rate set by the divider, and hands each word to a downstream serializer. A drop of the status line stops the stream, flags an error and sends the block back to wait for readiness. A rise of the done line ends the run. The block then stays idle until a reconfigure pulse, which picks a page again and starts over without reading the option words a second time.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `flash_req`, `out_valid`, `cfg_error` and `cfg_idle` are 0. After reset the first 32 flash reads address OPT_BASE (default 0x8000) up to OPT_BASE+31 in rising order, and each is issued at least OPT_PACE (default 4) cycles after the one before it.
- R2: Once all 32 option words are read, the outputs decode option word 0: `cfg_scheme` = bits [1:0], `cfg_decomp_en` = bit 2, `cfg_clk_div` = bits [10:3].
- R3: For page p, option word 2+2p holds the start word address and option word 3+2p holds the length in words. A transfer reads exactly that many words, at start, start+1 and onward in rising order.
- R4: The page number is taken from `page_sel` while `rst_n` is low and in a cycle where `reconfig` is high. Changes of `page_sel` at other times do not change which page is streamed.
- R5: No page-data read is issued unless `fpga_status` was 1 and `fpga_done` was 0 in the issuing cycle. While that condition is false after the options are loaded, `flash_req` stays 0.
- R6: Two consecutive reads of one transfer are at least `cfg_clk_div`+1 cycles apart.
- R7: At most one flash read is outstanding. No `flash_req` comes between a request and its `flash_valid`.
- R8: A word returned on `flash_valid` during a transfer appears on `out_data` with `out_valid` high exactly one cycle later. Words returned outside a transfer are never forwarded.
- R9: If `fpga_status` is 0 during a transfer, `cfg_error` is 1 from the next cycle and no further reads are issued. When readiness returns, the same page is streamed again from its start address, and `cfg_error` returns to 0 at that restart.
- R10: If `fpga_done` is 1 during a transfer, `cfg_idle` is 1 from the next cycle. No reads are issued and no words are forwarded until a reconfigure or a reset.
- R11: After a `reconfig` pulse, the block reads only the newly chosen page, once readiness holds. It does not read the option area again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_sel | input | 3 | Page number, captured in reset and on reconfigure |
| reconfig | input | 1 | One-cycle request to choose a page again and restart |
| fpga_status | input | 1 | FPGA status, high when healthy |
| fpga_done | input | 1 | FPGA done indication |
| flash_req | output | 1 | One-cycle flash read request |
| flash_addr | output | ADDR_W | Word address of the request |
| flash_valid | input | 1 | One-cycle read response strobe |
| flash_data | input | 16 | Read response word |
| out_valid | output | 1 | Data word valid for the serializer |
| out_data | output | 16 | Data word for the serializer |
| cfg_scheme | output | 2 | Decoded scheme code |
| cfg_decomp_en | output | 1 | Decoded decompression enable |
| cfg_clk_div | output | 8 | Decoded streaming divider |
| xfer_active | output | 1 | High while a page transfer is running |
| cfg_idle | output | 1 | High after done, until reconfigure |
| cfg_error | output | 1 | Set by a status drop during a transfer |

## Verification
The properties rely on the flash side answering each request with exactly one `flash_valid` pulse, arriving at least one cycle after the request and never without a request. The bench's flash model keeps to this by answering each request with one pulse after a random delay of one to four cycles. The properties also assume that `flash_valid` never arrives during reset. The bench therefore asserts reset only while no read is in flight. The FPGA lines and `reconfig` change on the falling edge, as any synchronous source would drive them. `reconfig` is a single-cycle pulse.

// File: rtl/cfg_seq_pkg.sv
// Shared sizes, FSM encoding and decoded option fields for the
// configuration sequencer. Assumes 16-bit flash words.
package cfg_seq_pkg;
    localparam int WORD_W    = 16;
    localparam int OPT_WORDS = 32;
    localparam int PAGES     = 8;
    localparam int PAGE_W    = $clog2(PAGES);
    localparam int IDX_W     = $clog2(OPT_WORDS);
    localparam int OCNT_W    = IDX_W + 1;
    localparam int DIV_W     = 8;

    typedef enum logic [1:0] {
        ST_OPT  = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_IDLE = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [1:0]       scheme;
        logic             decomp;
        logic [DIV_W-1:0] clk_div;
    } opt_cfg_t;
endpackage

// File: rtl/cfg_rate_gen.sv
// Down-counter that spaces flash requests: fire is high once the count
// reaches zero; take reloads it. Assumes take only when fire is high.
module cfg_rate_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CNT_W-1:0] reload,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;

    // Reload on a taken slot, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (take)      cnt <= reload;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign fire = (cnt == '0);
endmodule

// File: rtl/cfg_flash_port.sv
// Registers the flash request pulse and address and tracks the single
// outstanding read. Assumes one flash_valid per request, never without one.
module cfg_flash_port #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              flash_valid,
    output logic              flash_req,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              pending
);
    // Drive a one-cycle request and hold its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_req  <= 1'b0;
            flash_addr <= '0;
        end else begin
            flash_req <= issue;
            if (issue) flash_addr <= issue_addr;
        end
    end

    // Outstanding flag: set on issue, cleared by the response.
    always_ff @(posedge clk) begin
        if (!rst_n)           pending <= 1'b0;
        else if (issue)       pending <= 1'b1;
        else if (flash_valid) pending <= 1'b0;
    end
endmodule

// File: rtl/cfg_opt_store.sv
// Captures the option words as they arrive and decodes them: word 0 is the
// header, words 2+2p / 3+2p are page p start / length. Other words are dropped.
module cfg_opt_store
    import cfg_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [PAGE_W-1:0]        page,
    output opt_cfg_t                 cfg,
    output logic [WORD_W-1:0]        page_start,
    output logic [WORD_W-1:0]        page_len
);
    localparam int HDR_W = DIV_W + 3;
    localparam int TBL_N = 2 * PAGES;

    logic [HDR_W-1:0]  hdr;
    logic [WORD_W-1:0] tbl [TBL_N];

    // Header word capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hdr <= '0;
        else if (wr_en && wr_idx == '0)      hdr <= wr_data[HDR_W-1:0];
    end

    // One register per page-table word.
    for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n)                                   tbl[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i + 2))    tbl[i] <= wr_data;
        end
    end

    // Decode header fields and look up the chosen page.
    always_comb begin
        cfg.scheme  = hdr[1:0];
        cfg.decomp  = hdr[2];
        cfg.clk_div = hdr[HDR_W-1:3];
        page_start  = tbl[{page, 1'b0}];
        page_len    = tbl[{page, 1'b1}];
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
// Configuration sequencer top: option read, page choice, readiness wait,
// paced page streaming, error and done handling. Assumes synchronous FPGA
// lines and a one-cycle reconfig pulse.
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int unsigned OPT_BASE = 32'h8000,
    parameter int          OPT_PACE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        page_sel,
    input  logic              reconfig,
    input  logic              fpga_status,
    input  logic              fpga_done,
    output logic              flash_req,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic              flash_valid,
    input  logic [15:0]       flash_data,
    output logic              out_valid,
    output logic [15:0]       out_data,
    output logic [1:0]        cfg_scheme,
    output logic              cfg_decomp_en,
    output logic [7:0]        cfg_clk_div,
    output logic              xfer_active,
    output logic              cfg_idle,
    output logic              cfg_error
);
    localparam logic [OCNT_W-1:0] OPT_LAST = OCNT_W'(OPT_WORDS);

    seq_state_t           state;
    logic [OCNT_W-1:0]    opt_iss_cnt, opt_rcv_cnt;
    logic [PAGE_W-1:0]    page_q;
    logic [ADDR_W-1:0]    xfer_addr, issue_addr;
    logic [WORD_W-1:0]    remain, page_start, page_len;
    logic                 err_q, pending, fire, issue;
    logic                 want_opt, want_xfer, stream_ok, opt_wr;
    logic [DIV_W-1:0]     reload;
    opt_cfg_t             cfg;

    // Request decision for the option phase and the streaming phase.
    always_comb begin
        stream_ok  = fpga_status && !fpga_done;
        want_opt   = (state == ST_OPT) && (opt_iss_cnt != OPT_LAST);
        want_xfer  = (state == ST_XFER) && (remain != '0) && stream_ok && !reconfig;
        issue      = fire && !pending && (want_opt || want_xfer);
        issue_addr = (state == ST_OPT) ? ADDR_W'(OPT_BASE) + ADDR_W'(opt_iss_cnt) : xfer_addr;
        reload     = (state == ST_OPT) ? DIV_W'(OPT_PACE - 1) : cfg.clk_div;
        opt_wr     = (state == ST_OPT) && flash_valid;
    end

    cfg_rate_gen #(.CNT_W(DIV_W)) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (issue),
        .reload (reload),
        .fire   (fire)
    );

    cfg_flash_port #(.ADDR_W(ADDR_W)) i_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_addr  (issue_addr),
        .flash_valid (flash_valid),
        .flash_req   (flash_req),
        .flash_addr  (flash_addr),
        .pending     (pending)
    );

    cfg_opt_store i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (opt_wr),
        .wr_idx     (opt_rcv_cnt[IDX_W-1:0]),
        .wr_data    (flash_data),
        .page       (page_q),
        .cfg        (cfg),
        .page_start (page_start),
        .page_len   (page_len)
    );

    // Option read counters: requests issued and words received.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_iss_cnt <= '0;
            opt_rcv_cnt <= '0;
        end else begin
            if (issue && state == ST_OPT) opt_iss_cnt <= opt_iss_cnt + 1'b1;
            if (opt_wr)                   opt_rcv_cnt <= opt_rcv_cnt + 1'b1;
        end
    end

    // Sequencer FSM with page capture, transfer counters and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPT;
            page_q    <= page_sel;
            xfer_addr <= '0;
            remain    <= '0;
            err_q     <= 1'b0;
        end else begin
            case (state)
                ST_OPT: begin
                    if (opt_rcv_cnt == OPT_LAST) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (reconfig) begin
                        page_q <= page_sel;
                    end else if (stream_ok && !pending) begin
                        xfer_addr <= ADDR_W'(page_start);
                        remain    <= page_len;
                        err_q     <= 1'b0;
                        state     <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!fpga_status) begin
                        err_q <= 1'b1;
                        state <= ST_WAIT;
                    end else if (fpga_done) begin
                        state <= ST_IDLE;
                    end else if (reconfig) begin
                        page_q <= page_sel;
                        state  <= ST_WAIT;
                    end else if (issue) begin
                        xfer_addr <= xfer_addr + 1'b1;
                        remain    <= remain - 1'b1;
                    end
                end
                default: begin
                    if (reconfig) begin
                        page_q <= page_sel;
                        state  <= ST_WAIT;
                    end
                end
            endcase
        end
    end

    // Forward read data to the serializer only during a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= flash_valid && (state == ST_XFER);
            if (flash_valid && state == ST_XFER) out_data <= flash_data;
        end
    end

    assign cfg_scheme    = cfg.scheme;
    assign cfg_decomp_en = cfg.decomp;
    assign cfg_clk_div   = cfg.clk_div;
    assign xfer_active   = (state == ST_XFER);
    assign cfg_idle      = (state == ST_IDLE);
    assign cfg_error     = err_q;
endmodule

// File: rtl/cfg_seq_checker.sv
// Port-level properties of the configuration sequencer. Assumes each
// request gets exactly one flash_valid, at least one cycle later.
module cfg_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        fpga_status,
    input logic        fpga_done,
    input logic        flash_req,
    input logic        flash_valid,
    input logic [15:0] flash_data,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        xfer_active,
    input logic        cfg_idle,
    input logic        cfg_error,
    input logic [7:0]  cfg_clk_div
);
    logic       outst;
    logic       seg_req;
    logic [8:0] gap;

    // Checker-side view of the outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n)           outst <= 1'b0;
        else if (flash_req)   outst <= 1'b1;
        else if (flash_valid) outst <= 1'b0;
    end

    // Cycles since the last request, and whether this transfer has had one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '1;
            seg_req <= 1'b0;
        end else begin
            if (flash_req)      gap <= '0;
            else if (gap != '1) gap <= gap + 1'b1;
            if (!xfer_active)   seg_req <= 1'b0;
            else if (flash_req) seg_req <= 1'b1;
        end
    end

    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |-> !outst);

    p_stream_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && xfer_active && seg_req) |-> (gap >= {1'b0, cfg_clk_div}));

    p_ready_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && xfer_active) |-> ($past(fpga_status) && !$past(fpga_done)));

    p_error_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !fpga_status) |=> (cfg_error && !xfer_active));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && fpga_status && fpga_done) |=> cfg_idle);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_idle |-> (!flash_req && !out_valid));

    p_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(flash_valid) && out_data == $past(flash_data)));
endmodule

bind cfg_seq_ctrl cfg_seq_checker i_cfg_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fpga_status (fpga_status),
    .fpga_done   (fpga_done),
    .flash_req   (flash_req),
    .flash_valid (flash_valid),
    .flash_data  (flash_data),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .xfer_active (xfer_active),
    .cfg_idle    (cfg_idle),
    .cfg_error   (cfg_error),
    .cfg_clk_div (cfg_clk_div)
);

// File: tb/test_cfg_seq_ctrl.sv
// Bench for cfg_seq_ctrl: random-latency flash model, seeded random page
// table and page picks, directed error / done / reset cases.
module test_cfg_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int OPT_BASE   = 32'h8000;
    localparam int OPT_PACE   = 4;
    localparam int DIV        = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        page_sel = 3'd5;
    logic              reconfig = 1'b0;
    logic              fpga_status = 1'b0;
    logic              fpga_done = 1'b0;
    logic              flash_req;
    logic [ADDR_W-1:0] flash_addr;
    logic              flash_valid = 1'b0;
    logic [15:0]       flash_data = '0;
    logic              out_valid;
    logic [15:0]       out_data;
    logic [1:0]        cfg_scheme;
    logic              cfg_decomp_en;
    logic [7:0]        cfg_clk_div;
    logic              xfer_active, cfg_idle, cfg_error;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [15:0] opt_img [32];
    logic [15:0] pg_start [8];
    logic [15:0] pg_len [8];
    logic [ADDR_W-1:0] req_q [$];
    logic [15:0]       out_q [$];
    int cyc = 0, last_req_cyc = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    bit bench_pend = 0;

    cfg_seq_ctrl #(.ADDR_W(ADDR_W), .OPT_BASE(OPT_BASE), .OPT_PACE(OPT_PACE)) i_cfg_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .reconfig(reconfig),
        .fpga_status(fpga_status), .fpga_done(fpga_done),
        .flash_req(flash_req), .flash_addr(flash_addr),
        .flash_valid(flash_valid), .flash_data(flash_data),
        .out_valid(out_valid), .out_data(out_data),
        .cfg_scheme(cfg_scheme), .cfg_decomp_en(cfg_decomp_en), .cfg_clk_div(cfg_clk_div),
        .xfer_active(xfer_active), .cfg_idle(cfg_idle), .cfg_error(cfg_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [ADDR_W-1:0] a);
        if (a >= ADDR_W'(OPT_BASE) && a < ADDR_W'(OPT_BASE + 32))
            return opt_img[a - ADDR_W'(OPT_BASE)];
        return a[15:0] ^ 16'h5A3C;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_logs();
        req_q.delete();
        out_q.delete();
    endtask

    task automatic wait_reqs(input int n);
        for (int t = 0; t < 3000 && req_q.size() < n; t++) @(negedge clk);
        ticks(14);
    endtask

    task automatic pulse_reconfig(input logic [2:0] p);
        page_sel = p;
        reconfig = 1'b1;
        ticks(1);
        reconfig = 1'b0;
        page_sel = ~p;
    endtask

    // Compare the logged stream with page p (addresses and forwarded data).
    task automatic check_stream(input int p, input string req);
        wait_reqs(int'(pg_len[p]));
        check(req_q.size() == int'(pg_len[p]), req, req_q.size(), pg_len[p]);
        check(out_q.size() == int'(pg_len[p]), "R8", out_q.size(), pg_len[p]);
        for (int i = 0; i < req_q.size() && i < int'(pg_len[p]); i++) begin
            logic [ADDR_W-1:0] ea;
            ea = ADDR_W'(pg_start[p]) + ADDR_W'(i);
            check(req_q[i] == ea, req, req_q[i], ea);
            if (i < out_q.size()) check(out_q[i] == mem_word(ea), "R8", out_q[i], mem_word(ea));
        end
    endtask

    // Flash model: one response per request after 1..4 cycles.
    initial begin
        forever begin
            @(negedge clk);
            flash_valid = 1'b0;
            if (flash_req === 1'b1 && rst_n) begin
                logic [ADDR_W-1:0] a;
                int l;
                a = flash_addr;
                l = $urandom_range(1, 4);
                repeat (l) @(negedge clk);
                flash_valid = 1'b1;
                flash_data  = mem_word(a);
            end
        end
    end

    // Monitor: log requests and outputs; check spacing and single outstanding.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (flash_valid) bench_pend = 0;
            if (out_valid) out_q.push_back(out_data);
            if (flash_req === 1'b1) begin
                check(!bench_pend, "R7", bench_pend, 0);
                if (flash_addr == last_addr + 1'b1) begin
                    if (flash_addr < ADDR_W'(OPT_BASE) + 1'b1)
                        check(cyc - last_req_cyc >= DIV + 1, "R6", cyc - last_req_cyc, DIV + 1);
                    else
                        check(cyc - last_req_cyc >= OPT_PACE, "R1", cyc - last_req_cyc, OPT_PACE);
                end
                bench_pend = 1;
                last_req_cyc = cyc;
                last_addr = flash_addr;
                req_q.push_back(flash_addr);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D));
        opt_img[0] = {5'd0, 8'(DIV), 1'b1, 2'b10};
        opt_img[1] = 16'hBEEF;
        for (int p = 0; p < 8; p++) begin
            pg_start[p] = 16'h0800 * 16'(p) + 16'($urandom_range(0, 255));
            pg_len[p]   = 16'($urandom_range(2, 10));
        end
        pg_len[3] = 16'd1;
        pg_len[7] = 16'd40;
        for (int p = 0; p < 8; p++) begin
            opt_img[2 + 2*p] = pg_start[p];
            opt_img[3 + 2*p] = pg_len[p];
        end
        for (int w = 18; w < 32; w++) opt_img[w] = 16'($urandom);

        // Reset with page 5 selected, then move the pin away.
        ticks(3);
        check(flash_req == 0 && out_valid == 0, "R1", {flash_req, out_valid}, 0);
        check(cfg_error == 0 && cfg_idle == 0, "R1", {cfg_error, cfg_idle}, 0);
        rst_n = 1'b1;
        page_sel = 3'd2;

        // Option read with the FPGA not ready.
        wait_reqs(32);
        check(req_q.size() == 32, "R1", req_q.size(), 32);
        for (int i = 0; i < 32 && i < req_q.size(); i++)
            check(req_q[i] == ADDR_W'(OPT_BASE + i), "R1", req_q[i], OPT_BASE + i);
        check(cfg_scheme == 2'b10, "R2", cfg_scheme, 2);
        check(cfg_decomp_en == 1'b1, "R2", cfg_decomp_en, 1);
        check(cfg_clk_div == 8'(DIV), "R2", cfg_clk_div, DIV);
        clear_logs();
        ticks(50);
        check(req_q.size() == 0, "R5", req_q.size(), 0);

        // Ready: stream the page captured in reset.
        clear_logs();
        fpga_status = 1'b1;
        page_sel = 3'd6;
        check_stream(5, "R4");
        check(xfer_active == 1, "R3", xfer_active, 1);

        // Reconfigure while done is high: no reads until done falls.
        fpga_done = 1'b1;
        ticks(2);
        check(cfg_idle == 1, "R10", cfg_idle, 1);
        clear_logs();
        pulse_reconfig(3'd3);
        ticks(30);
        check(req_q.size() == 0, "R5", req_q.size(), 0);
        fpga_done = 1'b0;
        check_stream(3, "R11");

        // Status drop in the middle of page 7.
        clear_logs();
        pulse_reconfig(3'd7);
        for (int t = 0; t < 2000 && req_q.size() < 8; t++) @(negedge clk);
        fpga_status = 1'b0;
        ticks(2);
        check(cfg_error == 1, "R9", cfg_error, 1);
        check(xfer_active == 0, "R9", xfer_active, 0);
        clear_logs();
        ticks(30);
        check(req_q.size() == 0, "R9", req_q.size(), 0);
        check(out_q.size() == 0, "R8", out_q.size(), 0);
        clear_logs();
        fpga_status = 1'b1;
        check_stream(7, "R9");
        check(cfg_error == 0, "R9", cfg_error, 0);

        // Random page picks.
        for (int k = 0; k < 6; k++) begin
            logic [2:0] p;
            p = 3'($urandom_range(0, 7));
            clear_logs();
            pulse_reconfig(p);
            check_stream(int'(p), "R3");
        end

        // Done in the middle of page 7.
        clear_logs();
        pulse_reconfig(3'd7);
        for (int t = 0; t < 2000 && req_q.size() < 5; t++) @(negedge clk);
        fpga_done = 1'b1;
        ticks(2);
        check(cfg_idle == 1, "R10", cfg_idle, 1);
        clear_logs();
        ticks(60);
        check(req_q.size() == 0, "R10", req_q.size(), 0);
        check(out_q.size() == 0, "R10", out_q.size(), 0);

        // Reset restart: options read again, page from the reset-time pin.
        page_sel = 3'd6;
        rst_n = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        page_sel = 3'd1;
        fpga_done = 1'b0;
        clear_logs();
        wait_reqs(32 + int'(pg_len[6]));
        check(req_q.size() == 32 + int'(pg_len[6]), "R1", req_q.size(), 32 + pg_len[6]);
        if (req_q.size() > 32) begin
            check(req_q[0] == ADDR_W'(OPT_BASE), "R1", req_q[0], OPT_BASE);
            check(req_q[32] == ADDR_W'(pg_start[6]), "R4", req_q[32], pg_start[6]);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule